// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Channel

This block is one memory-to-memory copy channel. Software programs it through a small register file. Software places a list of descriptors in memory and writes the address of the first one to the next-descriptor register. It then sets the enable bit. The channel reads each descriptor over a word-wide request/acknowledge memory port and copies the requested region one 32-bit word at a time, reading the source word and then writing it to the destination. It then follows the descriptor's link. A zero link ends the chain.

Per-descriptor completion, chain end and error responses are recorded in sticky status bits. Software clears each of them by writing 1 to its position. A descriptor can ask for an interrupt when it completes. When the channel has gone idle, software can add more work: it writes a new descriptor address to the next-descriptor register and sets the resume bit.

Descriptor layout (32-bit words from the descriptor address):

| Word | Content |
|------|---------|
| 0 | link to the next descriptor (0 ends the chain) |
| 1 | source address |
| 2 | upper source address (ignored) |
| 3 | destination address |
| 4 | byte count (low CNT_W bits used) |
| 5 | control word: bit 4 requests an interrupt, bit 6 selects memory-to-memory |

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset all status bits read 0, the control register reads 0, the current-descriptor register at 0x0C reads 0, irq is low and mem_req is low.
- R2: When the channel starts on a descriptor address, it reads descriptor words 0 to 5 from that address in ascending order. The current-descriptor register at 0x0C then holds that address.
- R3: A memory-to-memory descriptor moves byte_count/4 words. The low two bits of the count are dropped. Word k is read from source+4k and then written to destination+4k, in ascending k. The byte-count register at 0x20 reads the remaining bytes, which is 0 after a count that is a multiple of 4.
- R4: When a descriptor is fetched, its link is loaded into the next-descriptor register at 0x10. After a descriptor completes, the channel fetches from that register. If the register is zero, the channel sets end-of-chain (status bit 8) and goes idle.
- R5: Each completed descriptor sets end-of-transfer (status bit 9). Status bits 9, 8, 5, 3 and 2 are cleared only by writing 1 to their own position. Writing 0 to a bit leaves it unchanged.
- R6: Completion of a descriptor whose control bit 4 is set drives irq high. irq stays high until software clears status bit 9. Any set error bit also drives irq high.
- R7: A descriptor with a byte count below 4, or with control bit 6 clear, makes no data access. It still completes with bit 9 and, if it asks for one, with its interrupt.
- R8: Control register at 0x00: bit 0 is enable and bit 1 is resume. Resume (reads 0) with enable set on an idle channel starts a fetch from the next-descriptor register, and so does setting enable from 0. Resume while the channel is busy is ignored.
- R9: When software clears enable, the channel stops at the next word boundary: after the word pair in flight, or at the end of a descriptor fetch. It makes no further memory access, does not set bit 9, and stays idle while enable is clear.
- R10: An error response stops the channel. An error while reading a descriptor sets bit 5. An error on a data read sets bit 3. An error on a data write sets bit 2.
- R11: mem_req stays high with a stable address, direction and write data until mem_ack. Every address is word-aligned.
- R12: Status bit 10 reads 1 from the start of a chain until it ends, stops or fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 6 | register byte offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address of the word |
| mem_wdata | output | 32 | write data |
| mem_ack | input | 1 | access complete |
| mem_err | input | 1 | error response, valid with mem_ack |
| mem_rdata | input | 32 | read data, valid with mem_ack |
| irq | output | 1 | interrupt request |

## Verification
The assertions watch every cycle for these properties:
- the memory request stays held and aligned until it is acknowledged;
- an error response drops busy;
- end-of-chain rises only together with idle;
- a disabled idle channel stays idle;
- a write of 1 clears end-of-transfer.

Other behaviour can only be shown by the bench's scenarios, where a queue of expected destination writes is compared against every write the channel makes. These scenarios cover:
- the order of the copied words;
- following the links through a chain;
- descriptors that move no data;
- the append sequence through resume;
- the word boundary at which a disable takes effect;
- which error bit each failing access sets.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

   localparam int unsigned REG_AW = 6;

   localparam logic [REG_AW-1:0] OFF_CTRL = 6'h00;
   localparam logic [REG_AW-1:0] OFF_STAT = 6'h04;
   localparam logic [REG_AW-1:0] OFF_CDR  = 6'h0C;
   localparam logic [REG_AW-1:0] OFF_NDR  = 6'h10;
   localparam logic [REG_AW-1:0] OFF_BCR  = 6'h20;

   localparam int unsigned CTL_EN     = 0;
   localparam int unsigned CTL_RESUME = 1;

   localparam int unsigned ST_WABORT = 2;
   localparam int unsigned ST_RABORT = 3;
   localparam int unsigned ST_FABORT = 5;
   localparam int unsigned ST_EOC    = 8;
   localparam int unsigned ST_EOT    = 9;
   localparam int unsigned ST_BUSY   = 10;

   localparam int unsigned DC_INT = 4;
   localparam int unsigned DC_M2M = 6;

   localparam int unsigned IDX_W = 3;
   localparam logic [IDX_W-1:0] W_LINK = 3'd0;
   localparam logic [IDX_W-1:0] W_SRC  = 3'd1;
   localparam logic [IDX_W-1:0] W_DST  = 3'd3;
   localparam logic [IDX_W-1:0] W_CNT  = 3'd4;
   localparam logic [IDX_W-1:0] W_CTL  = 3'd5;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_FETCH,
      ENG_RD,
      ENG_WR,
      ENG_DONE
   } eng_state_e;

endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
   import dma_chain_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned CNT_W    = 25,
   parameter bit          IRQ_ON_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic              busy,
   input  logic [AW-1:0]     cur_addr,
   input  logic [CNT_W-1:0]  remain,
   input  logic              ndr_load,
   input  logic [AW-1:0]     ndr_link,
   input  logic              evt_eot,
   input  logic              evt_eoc,
   input  logic              evt_int,
   input  logic              err_fetch,
   input  logic              err_rd,
   input  logic              err_wr,
   output logic              en,
   output logic              start,
   output logic [AW-1:0]     ndr,
   output logic              stat_eot,
   output logic              stat_eoc,
   output logic              irq
);

   localparam int unsigned NSTK = 6;

   logic              en_q;
   logic [AW-1:0]     ndr_q;
   logic [NSTK-1:0]   stk_q, stk_set, stk_clr;
   logic [DW-1:0]     status;
   logic              wr_ctrl, wr_stat, wr_ndr;

   assign wr_ctrl = reg_we && (reg_addr == OFF_CTRL);
   assign wr_stat = reg_we && (reg_addr == OFF_STAT);
   assign wr_ndr  = reg_we && (reg_addr == OFF_NDR);

   assign start = wr_ctrl && reg_wdata[CTL_EN] && !busy &&
                  (!en_q || reg_wdata[CTL_RESUME]);

   // sticky order: eot, eoc, fetch abort, read abort, write abort, irq pending
   assign stk_set = {evt_eot, evt_eoc, err_fetch, err_rd, err_wr, evt_int};
   assign stk_clr = wr_stat ? {reg_wdata[ST_EOT], reg_wdata[ST_EOC], reg_wdata[ST_FABORT],
                               reg_wdata[ST_RABORT], reg_wdata[ST_WABORT], reg_wdata[ST_EOT]}
                            : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ndr_q <= '0;
         stk_q <= '0;
      end else begin
         if (wr_ctrl) en_q <= reg_wdata[CTL_EN];
         if (ndr_load)    ndr_q <= ndr_link;
         else if (wr_ndr) ndr_q <= reg_wdata[AW-1:0];
         stk_q <= stk_set | (stk_q & ~stk_clr);
      end
   end

   always_comb begin
      status            = '0;
      status[ST_BUSY]   = busy;
      status[ST_EOT]    = stk_q[5];
      status[ST_EOC]    = stk_q[4];
      status[ST_FABORT] = stk_q[3];
      status[ST_RABORT] = stk_q[2];
      status[ST_WABORT] = stk_q[1];
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFF_CTRL: reg_rdata[CTL_EN] = en_q;
         OFF_STAT: reg_rdata = status;
         OFF_CDR:  reg_rdata = DW'(cur_addr);
         OFF_NDR:  reg_rdata = DW'(ndr_q);
         OFF_BCR:  reg_rdata = DW'(remain);
         default:  reg_rdata = '0;
      endcase
   end

   generate
      if (IRQ_ON_ERR) begin : g_irq_err
         assign irq = stk_q[0] | (|stk_q[3:1]);
      end else begin : g_irq_done
         assign irq = stk_q[0];
      end
   endgenerate

   assign en       = en_q;
   assign ndr      = ndr_q;
   assign stat_eot = stk_q[5];
   assign stat_eoc = stk_q[4];

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
   import dma_chain_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned CNT_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             en,
   input  logic [AW-1:0]    ndr_in,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic             mem_err,
   input  logic [DW-1:0]    mem_rdata,
   output logic             busy,
   output logic [AW-1:0]    cur_addr,
   output logic [CNT_W-1:0] remain,
   output logic             ndr_load,
   output logic [AW-1:0]    ndr_link,
   output logic             evt_eot,
   output logic             evt_eoc,
   output logic             evt_int,
   output logic             err_fetch,
   output logic             err_rd,
   output logic             err_wr
);

   localparam logic [AW-1:0]    STEP    = AW'(4);
   localparam logic [CNT_W-1:0] CSTEP   = CNT_W'(4);
   localparam logic [CNT_W-1:0] TWO_WRD = CNT_W'(8);

   eng_state_e        st_q;
   logic [IDX_W-1:0]  idx_q;
   logic [AW-1:0]     cur_q, link_q, src_q, dst_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              int_q;
   logic [DW-1:0]     buf_q;
   logic              acked, ok, bad, ndr_zero;

   assign mem_req  = (st_q == ENG_FETCH) || (st_q == ENG_RD) || (st_q == ENG_WR);
   assign mem_we   = (st_q == ENG_WR);
   assign mem_wdata = buf_q;

   always_comb begin
      case (st_q)
         ENG_RD:  mem_addr = src_q;
         ENG_WR:  mem_addr = dst_q;
         default: mem_addr = cur_q + (AW'(idx_q) << 2);
      endcase
   end

   assign acked    = mem_req && mem_ack;
   assign ok       = acked && !mem_err;
   assign bad      = acked && mem_err;
   assign ndr_zero = (ndr_in == '0);

   assign busy      = (st_q != ENG_IDLE);
   assign cur_addr  = cur_q;
   assign remain    = cnt_q;
   assign ndr_load  = (st_q == ENG_FETCH) && ok && (idx_q == W_CTL);
   assign ndr_link  = link_q;
   assign evt_eot   = (st_q == ENG_DONE);
   assign evt_int   = (st_q == ENG_DONE) && int_q;
   assign evt_eoc   = ndr_zero && ((st_q == ENG_DONE) || ((st_q == ENG_IDLE) && start));
   assign err_fetch = (st_q == ENG_FETCH) && bad;
   assign err_rd    = (st_q == ENG_RD) && bad;
   assign err_wr    = (st_q == ENG_WR) && bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         idx_q  <= '0;
         cur_q  <= '0;
         link_q <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         int_q  <= 1'b0;
         buf_q  <= '0;
      end else begin
         case (st_q)
            ENG_IDLE: begin
               if (start && !ndr_zero) begin
                  cur_q <= ndr_in;
                  idx_q <= '0;
                  st_q  <= ENG_FETCH;
               end
            end
            ENG_FETCH: begin
               if (bad) begin
                  st_q <= ENG_IDLE;
               end else if (ok) begin
                  case (idx_q)
                     W_LINK:  link_q <= mem_rdata[AW-1:0];
                     W_SRC:   src_q  <= mem_rdata[AW-1:0];
                     W_DST:   dst_q  <= mem_rdata[AW-1:0];
                     W_CNT:   cnt_q  <= mem_rdata[CNT_W-1:0];
                     W_CTL:   int_q  <= mem_rdata[DC_INT];
                     default: ;
                  endcase
                  if (idx_q == W_CTL) begin
                     if (!en)
                        st_q <= ENG_IDLE;
                     else if (mem_rdata[DC_M2M] && (cnt_q >= CSTEP))
                        st_q <= ENG_RD;
                     else
                        st_q <= ENG_DONE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ENG_RD: begin
               if (bad) begin
                  st_q <= ENG_IDLE;
               end else if (ok) begin
                  buf_q <= mem_rdata;
                  st_q  <= ENG_WR;
               end
            end
            ENG_WR: begin
               if (bad) begin
                  st_q <= ENG_IDLE;
               end else if (ok) begin
                  src_q <= src_q + STEP;
                  dst_q <= dst_q + STEP;
                  cnt_q <= cnt_q - CSTEP;
                  if (cnt_q < TWO_WRD) st_q <= ENG_DONE;
                  else if (!en)        st_q <= ENG_IDLE;
                  else                 st_q <= ENG_RD;
               end
            end
            ENG_DONE: begin
               if (ndr_zero || !en) begin
                  st_q <= ENG_IDLE;
               end else begin
                  cur_q <= ndr_in;
                  idx_q <= '0;
                  st_q  <= ENG_FETCH;
               end
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
   import dma_chain_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned DW         = 32,
   parameter int unsigned CNT_W      = 25,
   parameter bit          IRQ_ON_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [DW-1:0]     mem_rdata,
   output logic              irq
);

   generate
      if (DW != 32) begin : g_bad_dw
         $error("dma_chain_ctrl: DW must be 32");
      end
      if (AW != DW) begin : g_bad_aw
         $error("dma_chain_ctrl: AW must equal DW");
      end
      if ((CNT_W < 3) || (CNT_W > DW)) begin : g_bad_cnt
         $error("dma_chain_ctrl: CNT_W out of range");
      end
   endgenerate

   logic             busy_w, ctrl_en, start_w, ndr_load_w;
   logic             evt_eot, evt_eoc, evt_int, err_fetch, err_rd, err_wr;
   logic             stat_eot, stat_eoc;
   logic [AW-1:0]    ndr_w, cur_w, link_w;
   logic [CNT_W-1:0] remain_w;

   dma_chain_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .IRQ_ON_ERR(IRQ_ON_ERR)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy_w),
      .cur_addr  (cur_w),
      .remain    (remain_w),
      .ndr_load  (ndr_load_w),
      .ndr_link  (link_w),
      .evt_eot   (evt_eot),
      .evt_eoc   (evt_eoc),
      .evt_int   (evt_int),
      .err_fetch (err_fetch),
      .err_rd    (err_rd),
      .err_wr    (err_wr),
      .en        (ctrl_en),
      .start     (start_w),
      .ndr       (ndr_w),
      .stat_eot  (stat_eot),
      .stat_eoc  (stat_eoc),
      .irq       (irq)
   );

   dma_chain_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_w),
      .en        (ctrl_en),
      .ndr_in    (ndr_w),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_err   (mem_err),
      .mem_rdata (mem_rdata),
      .busy      (busy_w),
      .cur_addr  (cur_w),
      .remain    (remain_w),
      .ndr_load  (ndr_load_w),
      .ndr_link  (link_w),
      .evt_eot   (evt_eot),
      .evt_eoc   (evt_eoc),
      .evt_int   (evt_int),
      .err_fetch (err_fetch),
      .err_rd    (err_rd),
      .err_wr    (err_wr)
   );

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk
   import dma_chain_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic              mem_err,
   input logic [AW-1:0]     mem_addr,
   input logic [DW-1:0]     mem_wdata,
   input logic              busy,
   input logic              ctrl_en,
   input logic              stat_eot,
   input logic              stat_eoc,
   input logic              evt_eot,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DW-1:0]     reg_wdata
);

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && mem_err |=> !busy);

   p_eoc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_eoc) |-> !busy);

   p_off_stays_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en && !busy && !reg_we |=> !busy && !mem_req);

   p_eot_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && (reg_addr == OFF_STAT) && reg_wdata[ST_EOT] && !evt_eot |=> !stat_eot);

endmodule

bind dma_chain_ctrl dma_chain_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_err   (mem_err),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .busy      (busy_w),
   .ctrl_en   (ctrl_en),
   .stat_eot  (stat_eot),
   .stat_eoc  (stat_eoc),
   .evt_eot   (evt_eot),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata)
);

// File: tb/tb_dma_chain_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chain_ctrl;

   localparam int LAT = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        irq;

   always #10 clk = ~clk;

   dma_chain_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq)
   );

   logic [31:0] mem [0:1023];
   logic [31:0] exp_addr[$];
   logic [31:0] exp_data[$];
   logic [31:0] err_addr = 32'hFFFF_FFF0;
   int n_tests = 0;
   int n_fail  = 0;
   int rd_cnt  = 0;
   int wr_cnt  = 0;
   int lat     = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reference memory: acknowledges after LAT idle edges, checks each write against the queue
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0; mem_err = 1'b0; lat = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0; mem_err = 1'b0; lat = 0;
      end else if (mem_req) begin
         if (lat < LAT) lat++;
         else begin
            lat = 0;
            mem_ack = 1'b1;
            if (mem_addr == err_addr) mem_err = 1'b1;
            else if (mem_we) begin
               wr_cnt++;
               if (exp_addr.size() == 0) check(1'b0, "R3 unexpected write", mem_addr, 32'h0);
               else begin
                  logic [31:0] ea, ed;
                  ea = exp_addr.pop_front();
                  ed = exp_data.pop_front();
                  check(mem_addr == ea, "R3 write address", mem_addr, ea);
                  check(mem_wdata == ed, "R3 write data", mem_wdata, ed);
               end
               mem[mem_addr[11:2]] = mem_wdata;
            end else begin
               rd_cnt++;
               mem_rdata = mem[mem_addr[11:2]];
            end
         end
      end
   end

   task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_desc(input logic [31:0] base, input logic [31:0] link, input logic [31:0] src,
                           input logic [31:0] dst, input logic [31:0] cnt, input logic [31:0] ctl,
                           input bit expect_moves);
      mem[base[11:2]]       = link;
      mem[base[11:2] + 1]   = src;
      mem[base[11:2] + 2]   = 32'hDEAD_0002;
      mem[base[11:2] + 3]   = dst;
      mem[base[11:2] + 4]   = cnt;
      mem[base[11:2] + 5]   = ctl;
      for (int k = 0; k < int'(cnt / 4); k++) begin
         logic [31:0] v;
         v = {src[15:0], 16'(k)} ^ 32'hA5A5_0000;
         mem[src[11:2] + 10'(k)] = v;
         if (expect_moves && ctl[6]) begin
            exp_addr.push_back(dst + 32'(4 * k));
            exp_data.push_back(v);
         end
      end
   endtask

   task automatic wait_idle;
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         reg_rd(6'h04, s);
         if (!s[10]) break;
      end
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int rd0, wr0;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_rd(6'h04, r); check(r == 0, "R1 status", r, 0);
      reg_rd(6'h00, r); check(r == 0, "R1 control", r, 0);
      reg_rd(6'h0C, r); check(r == 0, "R1 current descriptor", r, 0);
      check(irq == 0 && mem_req == 0, "R1 irq/req", {30'b0, irq, mem_req}, 0);

      // single descriptor with interrupt
      put_desc(32'h100, 32'h0, 32'h400, 32'h800, 32'd16, 32'h50, 1'b1);
      rd0 = rd_cnt; wr0 = wr_cnt;
      reg_wr(6'h10, 32'h100);
      reg_wr(6'h00, 32'h1);
      reg_rd(6'h04, r); check(r[10] == 1'b1, "R12 busy after start", r, 32'h400);
      wait_idle();
      check(rd_cnt - rd0 == 10, "R2 read count", rd_cnt - rd0, 10);
      check(wr_cnt - wr0 == 4 && exp_addr.size() == 0, "R3 word count", wr_cnt - wr0, 4);
      check(mem[10'h200] == ({16'h0400, 16'd0} ^ 32'hA5A5_0000), "R3 dest word0", mem[10'h200], 0);
      reg_rd(6'h0C, r); check(r == 32'h100, "R2 current descriptor", r, 32'h100);
      reg_rd(6'h20, r); check(r == 0, "R3 remaining bytes", r, 0);
      reg_rd(6'h04, r); check(r == 32'h300, "R4 R5 eot+eoc, not busy", r, 32'h300);
      check(irq == 1'b1, "R6 irq raised", irq, 1);
      reg_wr(6'h04, 32'h0000_0200);
      reg_rd(6'h04, r); check(r == 32'h100, "R5 only eot cleared", r, 32'h100);
      check(irq == 1'b0, "R6 irq cleared with eot", irq, 0);
      reg_wr(6'h04, 32'h0);
      reg_rd(6'h04, r); check(r == 32'h100, "R5 zero write no effect", r, 32'h100);
      reg_wr(6'h04, 32'h100);

      // two-descriptor chain, interrupt only on the second
      put_desc(32'h140, 32'h180, 32'h480, 32'h880, 32'd8, 32'h40, 1'b1);
      put_desc(32'h180, 32'h0, 32'h4C0, 32'h8C0, 32'd12, 32'h50, 1'b1);
      rd0 = rd_cnt;
      reg_wr(6'h10, 32'h140);
      reg_wr(6'h00, 32'h3);
      wait_idle();
      check(exp_addr.size() == 0, "R4 chain moved all words", exp_addr.size(), 0);
      check(rd_cnt - rd0 == 17, "R4 chain reads", rd_cnt - rd0, 17);
      reg_rd(6'h0C, r); check(r == 32'h180, "R4 last descriptor", r, 32'h180);
      reg_rd(6'h10, r); check(r == 0, "R4 null link loaded", r, 0);
      check(irq == 1'b1, "R6 irq from second", irq, 1);
      reg_wr(6'h04, 32'h300);

      // no-move descriptors: zero count and non-memory mode
      put_desc(32'h1C0, 32'h1E0, 32'h500, 32'h900, 32'd0, 32'h50, 1'b1);
      put_desc(32'h1E0, 32'h0, 32'h540, 32'h940, 32'd8, 32'h10, 1'b1);
      rd0 = rd_cnt; wr0 = wr_cnt;
      reg_wr(6'h10, 32'h1C0);
      reg_wr(6'h00, 32'h3);
      wait_idle();
      check(rd_cnt - rd0 == 12, "R7 only descriptor reads", rd_cnt - rd0, 12);
      check(wr_cnt == wr0, "R7 no writes", wr_cnt - wr0, 0);
      reg_rd(6'h04, r); check(r == 32'h300, "R7 completes", r, 32'h300);
      check(irq == 1'b1, "R7 interrupt", irq, 1);
      reg_wr(6'h04, 32'h300);

      // resume with null next-descriptor: immediate end of chain
      reg_wr(6'h00, 32'h3);
      reg_rd(6'h04, r); check(r == 32'h100, "R8 resume on null link", r, 32'h100);
      reg_wr(6'h04, 32'h100);

      // append through resume, resume while busy ignored
      put_desc(32'h200, 32'h0, 32'h580, 32'h980, 32'd32, 32'h40, 1'b1);
      rd0 = rd_cnt;
      reg_wr(6'h10, 32'h200);
      reg_wr(6'h00, 32'h3);
      reg_wr(6'h00, 32'h3);
      wait_idle();
      check(rd_cnt - rd0 == 14, "R8 resume while busy ignored", rd_cnt - rd0, 14);
      check(exp_addr.size() == 0, "R8 appended copy done", exp_addr.size(), 0);
      reg_wr(6'h04, 32'h300);

      // disable mid-descriptor
      put_desc(32'h240, 32'h0, 32'h600, 32'hC00, 32'd64, 32'h40, 1'b1);
      wr0 = wr_cnt;
      reg_wr(6'h10, 32'h240);
      reg_wr(6'h00, 32'h3);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (wr_cnt - wr0 >= 2) break;
      end
      reg_wr(6'h00, 32'h0);
      wait_idle();
      r = 32'(wr_cnt);
      repeat (20) @(negedge clk);
      check(32'(wr_cnt) == r, "R9 no access after stop", 32'(wr_cnt), r);
      check(wr_cnt - wr0 < 16, "R9 stopped early", wr_cnt - wr0, 15);
      reg_rd(6'h04, r); check(r == 32'h0, "R9 no eot, idle", r, 0);
      exp_addr.delete(); exp_data.delete();
      reg_wr(6'h00, 32'h1);
      wait_idle();

      // data read error
      reg_wr(6'h04, 32'h32C);
      put_desc(32'h280, 32'h0, 32'h6C0, 32'hD00, 32'd8, 32'h40, 1'b0);
      err_addr = 32'h6C0;
      reg_wr(6'h10, 32'h280);
      reg_wr(6'h00, 32'h3);
      wait_idle();
      reg_rd(6'h04, r); check(r == 32'h8, "R10 read abort", r, 32'h8);
      check(irq == 1'b1, "R6 error irq", irq, 1);
      reg_wr(6'h04, 32'h2C);
      check(irq == 1'b0, "R6 error cleared", irq, 0);

      // descriptor fetch error
      err_addr = 32'h308;
      reg_wr(6'h10, 32'h300);
      reg_wr(6'h00, 32'h3);
      wait_idle();
      reg_rd(6'h04, r); check(r == 32'h20, "R10 fetch abort", r, 32'h20);
      reg_wr(6'h04, 32'h2C);

      // data write error
      put_desc(32'h340, 32'h0, 32'h700, 32'hE00, 32'd4, 32'h40, 1'b0);
      err_addr = 32'hE00;
      reg_wr(6'h10, 32'h340);
      reg_wr(6'h00, 32'h3);
      wait_idle();
      reg_rd(6'h04, r); check(r == 32'h4, "R10 write abort", r, 32'h4);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule